// File: doc/BRIEF.md
# Dual-Buffer Flash Operation Scheduler

This block is the control core of a page-organized serial flash with two SRAM page buffers. A front end that has already decoded the serial command hands it one request per cycle: an operation code, a buffer select, a page number and a data byte. The scheduler decides whether the request may start. It runs self-timed array operations against a simple page store, keeps the status byte up to date and drives an active-low ready/busy output.

Array operations and buffer operations overlap. While a self-timed array operation runs, the array and the buffer bound to that operation are locked. The other buffer and the status byte stay fully usable, so a host can fill one buffer while the other is being programmed. A request that conflicts with the lock, or that would change a protected page while write protect is low, gets a one-cycle reject pulse and changes nothing. Each page holds one data word, and each buffer holds one page image.

Top module: `flash_op_sched`

## Requirements
- R1: The status byte is {ready, compare flag, 3'b110, 3'b000}. Bit 7 is 1 when no timed operation runs, bit 6 is the compare flag and bits 5:3 are the fixed code 110.
- R2: Timed operations are transfer(5) and compare(6) at T_XFER cycles, program with erase(7), direct program(11) and auto rewrite(12) at T_ERS_PROG, program without erase(8) at T_PROG, page erase(9) at T_PG_ERASE and block erase(10) at T_BLK_ERASE. `rdy_busy_n` is low for exactly that many cycles, starting the cycle after acceptance, and always equals status bit 7.
- R3: Compare(6) sets bit 6 to 0 when the page equals the buffer and to 1 otherwise, and only on the final cycle of the operation.
- R4: Page read(4) and every timed operation are rejected while a timed operation runs.
- R5: While a timed operation that uses a buffer (codes 5, 6, 7, 8, 11, 12) runs, buffer read(1) and buffer write(2) to that buffer are rejected. The other buffer, status read(3), and both buffers during the erases (9, 10) are served.
- R6: With `wp_n` low, codes 7 to 12 are rejected when the target lies below PROT_PAGES. For block erase the target is the first page of the aligned BLOCK_PAGES block. With `wp_n` high, every page may be changed.
- R7: A rejected request raises `reject` for one cycle, one cycle after the request, with no response and no change to the array, the buffers, the flag or busy.
- R8: Driving `rst_n` low ends a running operation at once without applying its result. Busy clears and the compare flag keeps its previous value.
- R9: On completion, transfer copies the page into the buffer. Program with erase and direct program write the buffer into the page. Program without erase writes page AND buffer. Page erase sets the page to all ones, block erase does the same for every page of the aligned block, and auto rewrite leaves the page unchanged and reloads the buffer from it. Direct program writes `req_data` into its buffer when it is accepted.
- R10: Accepted reads (codes 1, 3, 4) return their data with `rsp_valid` one cycle after the request. Buffer write(2) stores `req_data`. Code 0 and codes 13 to 15 produce neither a response nor a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts operations |
| wp_n | input | 1 | Active-low write protect for the low pages |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_buf | input | 1 | Buffer select |
| req_page | input | PAGE_AW | Target page |
| req_data | input | DATA_W | Write data for buffer write and direct program |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| reject | output | 1 | Request refused pulse |
| rdy_busy_n | output | 1 | Low while a timed operation runs |
| status | output | 8 | Status byte |

## Verification
The assertions assume that `req_op`, `req_buf` and `req_page` are stable for the whole cycle in which `req_valid` is high. They also assume that page numbers stay below NUM_PAGES and that `wp_n` changes only between requests. The stimulus drives every request on the falling edge for exactly one cycle and then returns `req_valid` low. It uses only pages inside the array. It first erases or programs every page it later reads, so the compare flag and read data are known whenever they are observed.

// File: rtl/fos_pkg.sv
package fos_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_BUF_RD    = 4'd1,
        OP_BUF_WR    = 4'd2,
        OP_STAT_RD   = 4'd3,
        OP_PAGE_RD   = 4'd4,
        OP_XFER      = 4'd5,
        OP_CMP       = 4'd6,
        OP_PROG_ERS  = 4'd7,
        OP_PROG      = 4'd8,
        OP_PG_ERASE  = 4'd9,
        OP_BLK_ERASE = 4'd10,
        OP_DIRECT    = 4'd11,
        OP_REWRITE   = 4'd12
    } op_e;

    localparam logic [2:0] DENSITY_CODE = 3'b110;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fos_gate.sv
module fos_gate
    import fos_pkg::*;
#(
    parameter int PAGE_AW     = 9,
    parameter int PROT_PAGES  = 256,
    parameter int BLOCK_PAGES = 8,
    parameter int CNT_W       = 6,
    parameter int T_XFER      = 7,
    parameter int T_ERS_PROG  = 40,
    parameter int T_PROG      = 30,
    parameter int T_PG_ERASE  = 20,
    parameter int T_BLK_ERASE = 30
) (
    input  logic               valid,
    input  op_e                op,
    input  logic               buf_sel,
    input  logic [PAGE_AW-1:0] page,
    input  logic               wp_n,
    input  logic               busy,
    input  logic               lock_any,
    input  logic               lock_buf,
    output logic               accept,
    output logic               refuse,
    output logic               timed,
    output logic               locks_buf,
    output logic               modifies,
    output logic [CNT_W-1:0]   cycles
);
    localparam int BLK_SH = $clog2(BLOCK_PAGES);

    logic               known;
    logic               conflict;
    logic               guarded;
    logic [PAGE_AW-1:0] target;

    always_comb begin
        known     = 1'b1;
        timed     = 1'b0;
        locks_buf = 1'b0;
        modifies  = 1'b0;
        conflict  = 1'b0;
        cycles    = '0;
        case (op)
            OP_BUF_RD, OP_BUF_WR: conflict = busy && lock_any && (buf_sel == lock_buf);
            OP_STAT_RD:           conflict = 1'b0;
            OP_PAGE_RD:           conflict = busy;
            OP_XFER, OP_CMP: begin
                timed = 1'b1; locks_buf = 1'b1; cycles = CNT_W'(T_XFER);
            end
            OP_PROG_ERS, OP_DIRECT, OP_REWRITE: begin
                timed = 1'b1; locks_buf = 1'b1; modifies = 1'b1;
                cycles = CNT_W'(T_ERS_PROG);
            end
            OP_PROG: begin
                timed = 1'b1; locks_buf = 1'b1; modifies = 1'b1;
                cycles = CNT_W'(T_PROG);
            end
            OP_PG_ERASE: begin
                timed = 1'b1; modifies = 1'b1; cycles = CNT_W'(T_PG_ERASE);
            end
            OP_BLK_ERASE: begin
                timed = 1'b1; modifies = 1'b1; cycles = CNT_W'(T_BLK_ERASE);
            end
            default: known = 1'b0;
        endcase
        if (timed && busy) conflict = 1'b1;
        target  = (op == OP_BLK_ERASE) ? ((page >> BLK_SH) << BLK_SH) : page;
        guarded = modifies && !wp_n && (32'(target) < 32'(PROT_PAGES));
        refuse  = valid && known && (conflict || guarded);
        accept  = valid && known && !(conflict || guarded);
    end

endmodule

// File: rtl/fos_timer.sv
module fos_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             running,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = cycles - CNT_W'(1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign running = tmr_q.run;
    assign done    = tmr_q.run && (tmr_q.cnt == '0);

    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tmr_q.run);

endmodule

// File: rtl/fos_array.sv
module fos_array #(
    parameter int NUM_PAGES   = 512,
    parameter int DATA_W      = 8,
    parameter int BLOCK_PAGES = 8,
    localparam int PAGE_AW    = $clog2(NUM_PAGES)
) (
    input  logic                    clk,
    input  logic [PAGE_AW-1:0]      rd_page,
    output logic [DATA_W-1:0]       page_rdata,
    output logic [1:0][DATA_W-1:0]  buf_rdata,
    input  logic                    page_we,
    input  logic                    blk_clear,
    input  logic [PAGE_AW-1:0]      wr_page,
    input  logic [DATA_W-1:0]       page_wdata,
    input  logic                    ubuf_we,
    input  logic                    ubuf_sel,
    input  logic [DATA_W-1:0]       ubuf_wdata,
    input  logic                    obuf_we,
    input  logic                    obuf_sel,
    input  logic [DATA_W-1:0]       obuf_wdata
);
    localparam int BLK_SH = $clog2(BLOCK_PAGES);

    logic [DATA_W-1:0] mem_q [NUM_PAGES];

    always_ff @(posedge clk) begin
        if (page_we) begin
            mem_q[wr_page] <= page_wdata;
        end else if (blk_clear) begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                if ((PAGE_AW'(i) >> BLK_SH) == (wr_page >> BLK_SH))
                    mem_q[i] <= '1;
            end
        end
    end

    assign page_rdata = mem_q[rd_page];

    for (genvar g = 0; g < 2; g++) begin : g_buf
        logic [DATA_W-1:0] img_q;
        always_ff @(posedge clk) begin
            if (ubuf_we && (ubuf_sel == 1'(g)))      img_q <= ubuf_wdata;
            else if (obuf_we && (obuf_sel == 1'(g))) img_q <= obuf_wdata;
        end
        assign buf_rdata[g] = img_q;
    end

endmodule

// File: rtl/flash_op_sched.sv
module flash_op_sched
    import fos_pkg::*;
#(
    parameter int NUM_PAGES   = 512,
    parameter int DATA_W      = 8,
    parameter int PROT_PAGES  = 256,
    parameter int BLOCK_PAGES = 8,
    parameter int T_XFER      = 7,
    parameter int T_ERS_PROG  = 40,
    parameter int T_PROG      = 30,
    parameter int T_PG_ERASE  = 20,
    parameter int T_BLK_ERASE = 30,
    localparam int PAGE_AW    = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wp_n,
    input  logic               req_valid,
    input  logic [3:0]         req_op,
    input  logic               req_buf,
    input  logic [PAGE_AW-1:0] req_page,
    input  logic [DATA_W-1:0]  req_data,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               reject,
    output logic               rdy_busy_n,
    output logic [7:0]         status
);
    localparam int T_MAX = max_of(max_of(T_XFER, T_ERS_PROG),
                                  max_of(T_PROG, max_of(T_PG_ERASE, T_BLK_ERASE)));
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        op_e                op;
        logic [PAGE_AW-1:0] page;
        logic               buf_sel;
        logic               lock_any;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rsp_data;
        logic               reject;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic cmp_q;

    op_e                    req_op_e;
    logic                   g_accept, g_refuse, g_timed, g_locks, g_modifies;
    logic [CNT_W-1:0]       g_cycles;
    logic                   tmr_start, tmr_running, tmr_done;
    logic [PAGE_AW-1:0]     rd_page;
    logic [DATA_W-1:0]      page_rdata;
    logic [1:0][DATA_W-1:0] buf_rdata;
    logic                   page_we, blk_clear, ubuf_we, obuf_we;
    logic [DATA_W-1:0]      page_wdata, obuf_wdata;
    logic [DATA_W-1:0]      op_buf;

    assign req_op_e = op_e'(req_op);

    fos_gate #(
        .PAGE_AW(PAGE_AW), .PROT_PAGES(PROT_PAGES), .BLOCK_PAGES(BLOCK_PAGES),
        .CNT_W(CNT_W), .T_XFER(T_XFER), .T_ERS_PROG(T_ERS_PROG), .T_PROG(T_PROG),
        .T_PG_ERASE(T_PG_ERASE), .T_BLK_ERASE(T_BLK_ERASE)
    ) u_gate (
        .valid(req_valid), .op(req_op_e), .buf_sel(req_buf), .page(req_page),
        .wp_n(wp_n), .busy(tmr_running), .lock_any(ctl_q.lock_any),
        .lock_buf(ctl_q.buf_sel), .accept(g_accept), .refuse(g_refuse),
        .timed(g_timed), .locks_buf(g_locks), .modifies(g_modifies),
        .cycles(g_cycles)
    );

    assign tmr_start = g_accept && g_timed;

    fos_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .cycles(g_cycles),
        .running(tmr_running), .done(tmr_done)
    );

    assign rd_page = tmr_running ? ctl_q.page : req_page;
    assign op_buf  = buf_rdata[ctl_q.buf_sel];

    always_comb begin
        page_we    = 1'b0;
        blk_clear  = 1'b0;
        obuf_we    = 1'b0;
        page_wdata = op_buf;
        obuf_wdata = page_rdata;
        if (tmr_done) begin
            case (ctl_q.op)
                OP_XFER, OP_REWRITE:    obuf_we = 1'b1;
                OP_PROG_ERS, OP_DIRECT: page_we = 1'b1;
                OP_PROG: begin
                    page_we    = 1'b1;
                    page_wdata = page_rdata & op_buf;
                end
                OP_PG_ERASE: begin
                    page_we    = 1'b1;
                    page_wdata = '1;
                end
                OP_BLK_ERASE: blk_clear = 1'b1;
                default: ;
            endcase
        end
    end

    assign ubuf_we = g_accept && ((req_op_e == OP_BUF_WR) || (req_op_e == OP_DIRECT));

    fos_array #(
        .NUM_PAGES(NUM_PAGES), .DATA_W(DATA_W), .BLOCK_PAGES(BLOCK_PAGES)
    ) u_array (
        .clk(clk), .rd_page(rd_page), .page_rdata(page_rdata), .buf_rdata(buf_rdata),
        .page_we(page_we), .blk_clear(blk_clear), .wr_page(ctl_q.page),
        .page_wdata(page_wdata), .ubuf_we(ubuf_we), .ubuf_sel(req_buf),
        .ubuf_wdata(req_data), .obuf_we(obuf_we), .obuf_sel(ctl_q.buf_sel),
        .obuf_wdata(obuf_wdata)
    );

    always_ff @(posedge clk) begin
        if (tmr_done && (ctl_q.op == OP_CMP))
            cmp_q <= (page_rdata != op_buf);
    end

    assign status     = {~tmr_running, cmp_q, DENSITY_CODE, 3'b000};
    assign rdy_busy_n = ~tmr_running;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.reject    = g_refuse;
        if (g_accept) begin
            case (req_op_e)
                OP_BUF_RD: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = buf_rdata[req_buf];
                end
                OP_STAT_RD: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = DATA_W'(status);
                end
                OP_PAGE_RD: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = page_rdata;
                end
                default: ;
            endcase
        end
        if (tmr_start) begin
            ctl_d.op       = req_op_e;
            ctl_d.page     = req_page;
            ctl_d.buf_sel  = req_buf;
            ctl_d.lock_any = g_locks;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.op <= OP_NONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_data  = ctl_q.rsp_data;
    assign reject    = ctl_q.reject;

    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> !rdy_busy_n);

    assert_locked_buf_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ubuf_we && tmr_running && ctl_q.lock_any) |-> (req_buf != ctl_q.buf_sel));

    assert_low_pages_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_start && g_modifies && !wp_n) |-> (32'(req_page) >= 32'(PROT_PAGES)));

    assert_reject_no_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !rsp_valid);

    assert_array_write_only_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_we || blk_clear) |-> tmr_running);

endmodule

// File: tb/sim_flash_op_sched.sv
module sim_flash_op_sched;

    localparam int NP = 512, PROT = 256, BLK = 8;
    localparam int TX = 7, TEP = 40, TP = 30, TPE = 20, TBE = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = 4'd0;
    logic       req_buf = 1'b0;
    logic [8:0] req_page = '0;
    logic [7:0] req_data = '0;
    logic       rsp_valid, reject, rdy_busy_n;
    logic [7:0] rsp_data, status;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    always #4 clk = ~clk;

    flash_op_sched #(
        .NUM_PAGES(NP), .DATA_W(8), .PROT_PAGES(PROT), .BLOCK_PAGES(BLK),
        .T_XFER(TX), .T_ERS_PROG(TEP), .T_PROG(TP), .T_PG_ERASE(TPE), .T_BLK_ERASE(TBE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_op(req_op),
        .req_buf(req_buf), .req_page(req_page), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .reject(reject),
        .rdy_busy_n(rdy_busy_n), .status(status)
    );

    // behavioural reference model
    logic [7:0] m_page [NP];
    logic [7:0] m_buf [2];
    logic       m_cmp;
    bit         m_busy, m_lock, m_rsp_v, m_rej;
    logic [7:0] m_rsp_d;
    int         m_rem, m_op, m_pg, m_bi;

    function automatic int dur(input int op);
        case (op)
            5, 6:      return TX;
            7, 11, 12: return TEP;
            8:         return TP;
            9:         return TPE;
            default:   return TBE;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_rem = 0; m_rsp_v = 0; m_rej = 0; m_lock = 0;
        end else begin
            int  op, pg, lo;
            bit  known, arr, timed, locks, modb, rej, acc;
            logic [7:0] stat;
            op    = int'(req_op);
            pg    = int'(req_page);
            stat  = {!m_busy, m_cmp, 3'b110, 3'b000};
            known = (op >= 1) && (op <= 12);
            arr   = op >= 4;
            timed = op >= 5;
            locks = (op >= 5 && op <= 8) || op == 11 || op == 12;
            modb  = op >= 7;
            lo    = (op == 10) ? (pg / BLK) * BLK : pg;
            rej   = (arr && m_busy)
                  || ((op == 1 || op == 2) && m_busy && m_lock && (int'(req_buf) == m_bi))
                  || (modb && !wp_n && lo < PROT);
            acc   = req_valid && known && !rej;
            m_rej = req_valid && known && rej;
            m_rsp_v = acc && (op == 1 || op == 3 || op == 4);
            if (m_rsp_v)
                m_rsp_d = (op == 1) ? m_buf[req_buf] : (op == 3) ? stat : m_page[pg];
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0;
                    case (m_op)
                        5, 12: m_buf[m_bi] = m_page[m_pg];
                        6:     m_cmp = (m_page[m_pg] != m_buf[m_bi]);
                        7, 11: m_page[m_pg] = m_buf[m_bi];
                        8:     m_page[m_pg] = m_page[m_pg] & m_buf[m_bi];
                        9:     m_page[m_pg] = 8'hFF;
                        10: for (int i = 0; i < NP; i++)
                                if (i / BLK == m_pg / BLK) m_page[i] = 8'hFF;
                        default: ;
                    endcase
                end
            end
            if (acc && (op == 2 || op == 11)) m_buf[req_buf] = req_data;
            if (acc && timed) begin
                m_busy = 1; m_rem = dur(op); m_op = op; m_pg = pg;
                m_bi = int'(req_buf); m_lock = locks;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycle, act, exp);
        end
    endtask

    // compare on every clock, shortly after the edge
    always begin
        @(posedge clk);
        #2;
        cycle++;
        chk(rdy_busy_n === !m_busy, "R2 busy", {7'd0, rdy_busy_n}, {7'd0, !m_busy});
        chk(status[7] === !m_busy && status[5:0] === 6'b110000, "R1 status",
            status, {!m_busy, status[6], 6'b110000});
        chk(status[6] === m_cmp, "R3 R8 compare flag", {7'd0, status[6]}, {7'd0, m_cmp});
        chk(reject === m_rej, "R4 R5 R6 R7 reject", {7'd0, reject}, {7'd0, m_rej});
        chk(rsp_valid === m_rsp_v, "R10 rsp_valid", {7'd0, rsp_valid}, {7'd0, m_rsp_v});
        if (m_rsp_v) chk(rsp_data === m_rsp_d, "R9 R10 rsp_data", rsp_data, m_rsp_d);
        if (cycle > 50000) begin
            chk(1'b0, "watchdog", 8'd0, 8'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input int op, input bit b, input int pg, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'(op); req_buf = b; req_page = 9'(pg); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!rdy_busy_n) @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdy_busy_n === 1'b1 && status[7] === 1'b1, "R1 reset ready", status, 8'h80);
        chk(status[5:3] === 3'b110, "R1 density code", {5'd0, status[5:3]}, 8'd6);

        // R9 erase then read back
        issue(9, 0, 300, 0); wait_ready();
        issue(4, 0, 300, 0);
        // R5 concurrent access during program with erase from buffer 0
        issue(2, 0, 0, 8'hA5);
        issue(7, 0, 300, 0);
        issue(2, 1, 0, 8'h3C);
        issue(1, 1, 0, 0);
        issue(2, 0, 0, 8'h11);   // R5 rejected
        issue(1, 0, 0, 0);       // R5 rejected
        issue(3, 0, 0, 0);       // R1 busy status
        issue(4, 0, 300, 0);     // R4 rejected
        issue(9, 0, 5, 0);       // R4 rejected
        chk(rdy_busy_n === 1'b0, "R2 still busy", {7'd0, rdy_busy_n}, 8'd0);
        wait_ready();
        issue(4, 0, 300, 0);
        issue(1, 0, 0, 0);       // R7 buffer 0 unchanged by rejected write
        // R3 compare match then mismatch
        issue(6, 0, 300, 0); wait_ready(); issue(3, 0, 0, 0);
        chk(status[6] === 1'b0, "R3 match flag", {7'd0, status[6]}, 8'd0);
        issue(2, 0, 0, 8'h5A);
        issue(6, 0, 300, 0); wait_ready(); issue(3, 0, 0, 0);
        chk(status[6] === 1'b1, "R3 mismatch flag", {7'd0, status[6]}, 8'd1);
        // R9 transfer, program without erase
        issue(5, 1, 300, 0); wait_ready(); issue(1, 1, 0, 0);
        issue(2, 1, 0, 8'h0F);
        issue(8, 1, 300, 0); wait_ready(); issue(4, 0, 300, 0);
        // R5 both buffers open during erase
        issue(9, 0, 10, 0);
        issue(2, 0, 0, 8'h66); issue(2, 1, 0, 8'h77); issue(1, 1, 0, 0);
        wait_ready();
        // R6 protection
        issue(11, 1, 10, 8'h77); wait_ready();
        wp_n = 1'b0;
        issue(9, 0, 10, 0);
        issue(10, 0, 250, 0);
        issue(7, 0, 255, 0);
        issue(4, 0, 10, 0);
        chk(rdy_busy_n === 1'b1, "R6 nothing started", {7'd0, rdy_busy_n}, 8'd1);
        issue(11, 0, 304, 8'h12); wait_ready();
        issue(10, 0, 301, 0); wait_ready();
        issue(4, 0, 296, 0); issue(4, 0, 303, 0); issue(4, 0, 304, 0);
        wp_n = 1'b1;
        // R9 auto rewrite
        issue(2, 0, 0, 8'hEE);
        issue(12, 0, 304, 0); wait_ready();
        issue(1, 0, 0, 0); issue(4, 0, 304, 0);
        // R10 undefined codes ignored
        issue(15, 0, 0, 0); issue(0, 0, 0, 0); issue(13, 1, 3, 0);
        // R8 reset aborts compare and erase
        issue(2, 0, 0, 8'h00);
        issue(6, 0, 304, 0);
        repeat (3) @(negedge clk);
        pulse_reset();
        @(negedge clk);
        chk(rdy_busy_n === 1'b1, "R8 abort clears busy", {7'd0, rdy_busy_n}, 8'd1);
        chk(status[6] === 1'b1, "R8 flag kept", {7'd0, status[6]}, 8'd1);
        issue(9, 0, 10, 0);
        repeat (5) @(negedge clk);
        pulse_reset();
        issue(4, 0, 10, 0);
        @(negedge clk);
        chk(m_page[10] === 8'h77, "R8 erase not applied (model)", m_page[10], 8'h77);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule